// File: doc/BRIEF.md
# Shared Packet Buffer Page Allocator with Transmit Reserve

This block hands out fixed-size pages of a shared packet buffer to a transmit path and a receive path. A bitmap tracks which pages are free. Each allocation takes the lowest-numbered free page and reports it with a one-cycle grant pulse. If no page can be given, a one-cycle failure pulse is raised instead. Pages come back through a release port. A reset-allocator command frees every page at once.

Free memory is counted in units of 256 times a fixed size multiplier, so with a multiplier of 2 one unit is 512 bytes and a page of 4 units is 2 KB. The host can program a reserve byte through a small register port. The reserve holds back free memory for transmit, so receive traffic cannot fill the whole buffer. A receive request succeeds only while free memory stays above the reserve. Transmit requests ignore the reserve. The reserve is measured against the memory that is free at the moment of the request. It does not shrink as transmit pages are taken.

Top module: `pkt_page_alloc`

## Requirements
- R1: After hardware reset, all pages are free, the reserve reads 0, the free readout equals pages*units-per-page (0x20 by default), and every grant or fail output is low.
- R2: The register port is read combinationally through `host_rdata`. Address 0 is the reserve and is read/write. Address 1 is the size multiplier and reads 0x02. Address 2 is the free memory in units; 256 or more units read as 0xFF. Writes to addresses 1 and 2 have no effect.
- R3: A transmit request pulse produces a `tx_grant` pulse on the next cycle. At the same time, `alloc_page` carries the number of the lowest free page, and that page leaves the free set.
- R4: When the reserve is 0, a receive request is granted whenever any page is free.
- R5: When the reserve is non-zero, a receive request is granted only if free units are strictly greater than the effective reserve. Otherwise it gets an `rx_fail` pulse. The effective reserve is the reserve rounded down to a whole number of pages, i.e. its two low bits are ignored by default.
- R6: Transmit requests ignore the reserve and are granted whenever a page is free.
- R7: A request made while no page is free gets a fail pulse on the next cycle, and no grant.
- R8: When transmit and receive requests arrive in the same cycle, only transmit is answered. The receive request gets neither a grant nor a fail.
- R9: Releasing an allocated page returns it to the free set. Releasing a page that is already free changes nothing.
- R10: The reset-allocator command frees all pages in one cycle and answers no request in that cycle. It leaves the reserve unchanged.
- R11: A reserve of 0xFF means the whole memory (256 units), so every receive request fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 2 | Register select |
| host_wdata | input | 8 | Register write data |
| host_rdata | output | 8 | Register read data (combinational) |
| tx_req | input | 1 | Transmit allocate request pulse |
| tx_grant | output | 1 | Transmit grant pulse |
| tx_fail | output | 1 | Transmit failure pulse |
| rx_req | input | 1 | Receive allocate request pulse |
| rx_grant | output | 1 | Receive grant pulse |
| rx_fail | output | 1 | Receive failure pulse |
| alloc_page | output | 3 | Page number of the latest grant |
| rel_valid | input | 1 | Page release strobe |
| rel_page | input | 3 | Page being released |
| alloc_reset | input | 1 | Reset-allocator command: free all pages |

## Verification
The bench builds the block with its defaults: 8 pages of 4 units each and a multiplier of 2. With so few pages, a short run of requests empties the buffer. Every reserve threshold from one page up to the full 32 units is crossed many times. Random mixes of requests, releases, reserve writes and allocator resets therefore hit exhaustion, the exact boundary where free memory equals the reserve, and tx/rx collisions, alongside directed checks of those same points.

// File: rtl/pkt_page_alloc.sv
module pkt_page_alloc #(
  parameter int NUM_PAGES      = 8,
  parameter int UNITS_PER_PAGE = 4,
  parameter logic [7:0] SIZE_MULT = 8'd2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_wr,
  input  logic [1:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  input  logic       tx_req,
  output logic       tx_grant,
  output logic       tx_fail,
  input  logic       rx_req,
  output logic       rx_grant,
  output logic       rx_fail,
  output logic [$clog2(NUM_PAGES)-1:0] alloc_page,
  input  logic       rel_valid,
  input  logic [$clog2(NUM_PAGES)-1:0] rel_page,
  input  logic       alloc_reset
);
  localparam int PW = $clog2(NUM_PAGES);
  localparam int UW = $clog2(NUM_PAGES * UNITS_PER_PAGE + 1);
  localparam int CW = (UW > 9) ? UW : 9;

  logic [NUM_PAGES-1:0] free_map, rel_mask, alloc_mask;
  logic [7:0]    reserve;
  logic [PW:0]   free_pages;
  logic [CW-1:0] free_units, reserve_eff;
  logic [PW-1:0] pick;
  logic any_free, rx_ok, tx_take, rx_take, rx_turn;

  always_comb begin
    free_pages = '0;
    pick = '0;
    for (int i = NUM_PAGES - 1; i >= 0; i--) begin
      free_pages = free_pages + (PW+1)'(free_map[i]);
      if (free_map[i]) pick = PW'(i);
    end
  end

  assign free_units  = CW'(free_pages) * CW'(UNITS_PER_PAGE);
  assign reserve_eff = (reserve == 8'hFF) ? CW'(256)
                     : CW'((int'(reserve) / UNITS_PER_PAGE) * UNITS_PER_PAGE);
  assign rx_ok    = (reserve == 8'h00) || (free_units > reserve_eff);
  assign any_free = |free_map;
  assign rx_turn  = rx_req && !tx_req && !alloc_reset;
  assign tx_take  = tx_req && !alloc_reset && any_free;
  assign rx_take  = rx_turn && any_free && rx_ok;

  assign alloc_mask = (tx_take || rx_take) ? (NUM_PAGES'(1) << pick) : '0;
  assign rel_mask   = rel_valid ? (NUM_PAGES'(1) << rel_page) : '0;

  always_comb begin
    case (host_addr)
      2'd0:    host_rdata = reserve;
      2'd1:    host_rdata = SIZE_MULT;
      2'd2:    host_rdata = (free_units >= CW'(256)) ? 8'hFF : free_units[7:0];
      default: host_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_map   <= '1;
      reserve    <= 8'h00;
      tx_grant   <= 1'b0;
      tx_fail    <= 1'b0;
      rx_grant   <= 1'b0;
      rx_fail    <= 1'b0;
      alloc_page <= '0;
    end else begin
      if (host_wr && host_addr == 2'd0) reserve <= host_wdata;
      free_map <= alloc_reset ? '1 : ((free_map | rel_mask) & ~alloc_mask);
      tx_grant <= tx_take;
      tx_fail  <= tx_req && !alloc_reset && !any_free;
      rx_grant <= rx_take;
      rx_fail  <= rx_turn && !(any_free && rx_ok);
      if (tx_take || rx_take) alloc_page <= pick;
    end
  end

  assert_one_response_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_grant, tx_fail, rx_grant, rx_fail}));

  assert_granted_page_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_grant || rx_grant) |-> !free_map[alloc_page]);

  assert_rx_above_reserve_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_grant |-> $past(reserve == 8'h00 || free_units > reserve_eff));

  assert_fail_when_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fail |-> $past(free_map == '0));

  assert_reset_cmd_frees_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(alloc_reset) |-> (&free_map && !tx_grant && !rx_grant && !tx_fail && !rx_fail));

  assert_reserve_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(alloc_reset && !(host_wr && host_addr == 2'd0)) |-> $stable(reserve));
endmodule

// File: tb/pkt_page_alloc_test.sv
module pkt_page_alloc_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic host_wr = 1'b0, tx_req = 1'b0, rx_req = 1'b0, rel_valid = 1'b0, alloc_reset = 1'b0;
  logic [1:0] host_addr = 2'd2;
  logic [7:0] host_wdata = 8'h00, host_rdata;
  logic [2:0] rel_page = 3'd0, alloc_page;
  logic tx_grant, tx_fail, rx_grant, rx_fail;

  int tests = 0, fails = 0;
  logic [7:0] m_free = 8'hFF;
  int m_res = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pkt_page_alloc uut (.*);

  function automatic int units(logic [7:0] f);
    return $countones(f) * 4;
  endfunction

  function automatic int lowest(logic [7:0] f);
    for (int i = 0; i < 8; i++) if (f[i]) return i;
    return 0;
  endfunction

  function automatic bit rx_allowed(logic [7:0] f, int r);
    int eff;
    eff = (r == 255) ? 256 : (r / 4) * 4;
    return (r == 0) || (units(f) > eff);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic rd(input int addr, input int exp, input string tag);
    host_addr = addr[1:0];
    #1;
    chk(tag, host_rdata, exp);
    host_addr = 2'd2;
  endtask

  task automatic step(input bit tx, input bit rx, input bit rv, input int rp,
                      input bit ar, input bit wr, input int wd, input string tag);
    bit anyf, okr, etg, etf, erg, erf;
    int lp;
    @(negedge clk);
    anyf = (m_free != 0);
    okr  = rx_allowed(m_free, m_res);
    lp   = lowest(m_free);
    etg = tx && !ar && anyf;
    etf = tx && !ar && !anyf;
    erg = rx && !tx && !ar && anyf && okr;
    erf = rx && !tx && !ar && !(anyf && okr);
    if (ar) m_free = 8'hFF;
    else begin
      if (rv) m_free[rp] = 1'b1;
      if (etg || erg) m_free[lp] = 1'b0;
    end
    if (wr) m_res = wd;
    tx_req = tx; rx_req = rx; rel_valid = rv; rel_page = rp[2:0];
    alloc_reset = ar; host_wr = wr; host_addr = wr ? 2'd0 : 2'd2; host_wdata = wd[7:0];
    @(posedge clk);
    #1;
    chk({tag, " flags"}, {tx_grant, tx_fail, rx_grant, rx_fail}, {etg, etf, erg, erf});
    if (etg || erg) chk({tag, " page"}, alloc_page, lp);
    tx_req = 0; rx_req = 0; rel_valid = 0; alloc_reset = 0; host_wr = 0;
    host_addr = 2'd2;
    #1;
    chk({tag, " free readout"}, host_rdata, units(m_free));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 grant/fail low", {tx_grant, tx_fail, rx_grant, rx_fail}, 0);
    rd(2, 8'h20, "R1 free readout after reset");
    rd(0, 0, "R1 reserve after reset");
    rst_n = 1'b1;
    rd(1, 2, "R2 multiplier reads 2");
    @(negedge clk); host_wr = 1; host_addr = 2'd1; host_wdata = 8'h55;
    @(negedge clk); host_wr = 0;
    rd(1, 2, "R2 multiplier write ignored");
    rd(0, 0, "R2 reserve untouched by addr1 write");
    step(0, 0, 0, 0, 0, 1, 8'h24, "R2 reserve write");
    rd(0, 8'h24, "R2 reserve readback");
    step(0, 0, 0, 0, 0, 1, 0, "R2 reserve clear");

    for (int i = 0; i < 8; i++) step(1, 0, 0, 0, 0, 0, 0, "R3 tx alloc lowest");
    step(1, 0, 0, 0, 0, 0, 0, "R7 tx empty fail");
    step(0, 1, 0, 0, 0, 0, 0, "R7 rx empty fail");
    step(0, 0, 1, 3, 0, 0, 0, "R9 release page 3");
    step(0, 0, 1, 3, 0, 0, 0, "R9 double release ignored");
    step(0, 1, 0, 0, 0, 0, 0, "R4 rx reserve zero gets page 3");
    step(0, 0, 1, 5, 0, 0, 0, "R9 release page 5");
    step(1, 1, 0, 0, 0, 0, 0, "R8 tx wins collision");

    step(0, 0, 0, 0, 0, 1, 8'h09, "R5 set reserve 9");
    step(0, 0, 0, 0, 1, 0, 0, "R10 allocator reset");
    rd(0, 8'h09, "R10 reserve kept");
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 0, 0, 0, "R6 tx fill");
    step(0, 1, 0, 0, 0, 0, 0, "R5 rx free 12 over reserve 8 granted");
    step(0, 1, 0, 0, 0, 0, 0, "R5 rx free 8 equal reserve refused");
    step(1, 0, 0, 0, 0, 0, 0, "R6 tx ignores reserve");
    step(1, 1, 0, 0, 1, 0, 0, "R10 reset cmd answers nothing");

    step(0, 0, 0, 0, 0, 1, 8'hFF, "R11 reserve all");
    step(0, 1, 0, 0, 0, 0, 0, "R11 rx refused with all free");
    step(0, 0, 0, 0, 0, 1, 8'h03, "R5 reserve below a page");
    step(0, 1, 0, 0, 0, 0, 0, "R5 reserve 3 acts as zero pages");

    for (int n = 0; n < 600; n++) begin
      int r;
      r = $urandom % 100;
      step(r < 35, (r >= 20 && r < 70), ($urandom % 3) == 0, $urandom % 8,
           r == 99, r >= 94 && r < 99, ($urandom % 2) ? ($urandom % 33) : 8'hFF,
           "R3/R4/R5/R6/R7/R8/R9 random");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule